// File: doc/BRIEF.md
# Stub Cache-Controller Register Bank

This block stands in for a level-2 cache controller on a register bus. It holds none of a cache's storage or machinery. It only answers the control and status registers that boot software touches inside a 4 KB window. Software can enable the cache, program the auxiliary, latency and filter registers, and read a cache identity word and a cache-type word. It can also issue maintenance operations, which complete at once.

Each access lasts one cycle. The master raises a select together with an address and a write flag, and on writes the data. Ready is always high. For a read, the read data is valid in the same cycle. A write takes effect at the clock edge that ends the access. An access to an offset the block does not decode reads as zero, changes nothing, and raises an error output for that cycle. The cache-type word is not stored. It is built from a base parameter and the current way-size and associativity bits of the auxiliary control register each time it is read.

Top module: `cache_ctl_shim`

## Requirements
- R1: Only address bits 11:0 select a register. Bits above them have no effect on read data, on the error output or on which register is written.
- R2: A read at offset 0x000 returns 0x410000C8.
- R3: Any access with an offset from 0x730 through 0x7FF reads as zero. Such an access does not raise the error output, and a write there changes no register.
- R4: A write to the control register at offset 0x100 stores only data bit 0. Bits 31:1 of that register always read as zero.
- R5: While the synchronous active-high reset is high at a clock edge, the following values are loaded at that edge, and any write in the same cycle is lost:
  - the auxiliary register is set to 0x02020000;
  - the control, tag-latency, data-latency, filter-start and filter-end registers are set to zero.
- R6: The tag-latency (0x108), data-latency (0x10C), filter-start (0xC00) and filter-end (0xC04) registers store and return all 32 written bits.
- R7: The auxiliary register at 0x104 stores and returns all 32 written bits.
- R8: A read at offset 0x004 returns BASE_TYPE OR (F << 18) OR (F << 6). F is the 5-bit value {aux[19:17], 0, aux[16]}, taken from the auxiliary value current in that cycle, so bits cleared in the auxiliary register stop appearing in the next read.
- R9: Offsets 0xF40, 0xF60 and 0xF80 read as zero, ignore writes and do not raise the error output.
- R10: An access to any other offset reads as zero, writes nothing, and drives the error output high in that access cycle only. Misaligned offsets such as 0x101 count as other offsets.
- R11: Offsets 0x000 and 0x004 are read-only. A write to either changes nothing and raises the error output, while a read of either does not.
- R12: Ready is always high. When select is low, read data is zero and the error output is low. During a write cycle, read data is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busSel | input | 1 | Access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address; only bits 11:0 decoded |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| busReady | output | 1 | Always high |
| busErr | output | 1 | High during an access to an undecoded offset |

## Verification
The bench builds the block with its default parameters: a 32-bit address and a base type of 0x1C100100. Every random address carries random upper 20 bits, so the wide address shows whether anything above bit 11 leaks into the decode. The default base type already has bits set inside both places where the way-size field lands. A design that replaced those bits instead of ORing into them would therefore read back differently. Random auxiliary values that are later cleared show whether the type word follows the current auxiliary contents or keeps old bits.

// File: rtl/cache_shim_pkg.sv
`timescale 1ns/1ps
package cache_shim_pkg;

  localparam int DATA_W   = 32;
  localparam int OFS_W    = 12;
  localparam int NUM_RW   = 6;
  localparam int IDX_W    = $clog2(NUM_RW);
  localparam int NUM_NULL = 3;

  localparam int IDX_CTRL   = 0;
  localparam int IDX_AUX    = 1;
  localparam int IDX_TAG    = 2;
  localparam int IDX_DATA   = 3;
  localparam int IDX_FSTART = 4;
  localparam int IDX_FEND   = 5;

  localparam logic [DATA_W-1:0] AUX_RESET = 32'h0202_0000;

  // Field placement of the cache-type readback
  localparam int WAYSZ_LSB  = 17;  // aux bits 19:17
  localparam int ASSOC_BIT  = 16;  // aux bit 16
  localparam int TYPE_POS_D = 18;  // upper copy of field
  localparam int TYPE_POS_I = 6;   // lower copy of field
  localparam int FIELD_W    = 5;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_ID   = 2'd1,
    RD_TYPE = 2'd2,
    RD_REG  = 2'd3
  } rdSrc_e;

  typedef struct packed {
    logic [NUM_RW-1:0] wrEn;
    rdSrc_e            rdSrc;
    logic [IDX_W-1:0]  rdIdx;
    logic              badAccess;
  } shimStrobe_t;

  function automatic logic [OFS_W-1:0] rwOffset(input int idx);
    case (idx)
      IDX_CTRL:   return 12'h100;
      IDX_AUX:    return 12'h104;
      IDX_TAG:    return 12'h108;
      IDX_DATA:   return 12'h10C;
      IDX_FSTART: return 12'hC00;
      default:    return 12'hC04;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] rwResetVal(input int idx);
    return (idx == IDX_AUX) ? AUX_RESET : '0;
  endfunction

  function automatic logic [DATA_W-1:0] rwWriteMask(input int idx);
    return (idx == IDX_CTRL) ? 32'h0000_0001 : '1;
  endfunction

  function automatic logic [OFS_W-1:0] nullOffset(input int idx);
    return OFS_W'(32'hF40 + 32'(idx) * 32'h20);
  endfunction

endpackage

// File: rtl/cache_shim_ctrl.sv
`timescale 1ns/1ps
module cache_shim_ctrl
  import cache_shim_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter logic [OFS_W:0]  MAINT_LO = 13'h730,
  parameter logic [OFS_W:0]  MAINT_HI = 13'h800
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output shimStrobe_t       strobe
);

  logic [OFS_W-1:0]  ofs;
  logic              inMaint;
  logic              isId;
  logic              isType;
  logic              isNull;
  logic [NUM_RW-1:0] rwHit;
  logic [NUM_NULL-1:0] nullHit;
  logic              readKnown;
  logic              writeKnown;

  assign ofs = busAddr[OFS_W-1:0];

  generate
    if (ADDR_W > OFS_W) begin : g_high
      logic unusedHighBits;
      assign unusedHighBits = ^busAddr[ADDR_W-1:OFS_W];
    end
  endgenerate

  assign inMaint = ({1'b0, ofs} >= MAINT_LO) && ({1'b0, ofs} < MAINT_HI);
  assign isId    = (ofs == 12'h000);
  assign isType  = (ofs == 12'h004);

  generate
    for (genvar g = 0; g < NUM_RW; g++) begin : g_rwHit
      assign rwHit[g] = (ofs == rwOffset(g));
    end
    for (genvar n = 0; n < NUM_NULL; n++) begin : g_nullHit
      assign nullHit[n] = (ofs == nullOffset(n));
    end
  endgenerate

  assign isNull     = |nullHit;
  assign writeKnown = inMaint | isNull | (|rwHit);
  assign readKnown  = writeKnown | isId | isType;

  always_comb begin
    strobe           = '0;
    strobe.rdSrc     = RD_ZERO;
    if (busSel) begin
      if (busWrite) begin
        strobe.wrEn      = inMaint ? '0 : rwHit;
        strobe.badAccess = !writeKnown;
      end else begin
        strobe.badAccess = !readKnown;
        if (inMaint || isNull) begin
          strobe.rdSrc = RD_ZERO;
        end else if (isId) begin
          strobe.rdSrc = RD_ID;
        end else if (isType) begin
          strobe.rdSrc = RD_TYPE;
        end else if (|rwHit) begin
          strobe.rdSrc = RD_REG;
          for (int i = 0; i < NUM_RW; i++) begin
            if (rwHit[i]) strobe.rdIdx = IDX_W'(i);
          end
        end
      end
    end
  end

endmodule

// File: rtl/cache_shim_datapath.sv
`timescale 1ns/1ps
module cache_shim_datapath
  import cache_shim_pkg::*;
#(
  parameter logic [DATA_W-1:0] BASE_TYPE = 32'h1C10_0100,
  parameter logic [DATA_W-1:0] CACHE_ID  = 32'h4100_00C8
) (
  input  logic              clk,
  input  logic              rst,
  input  shimStrobe_t       strobe,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [NUM_RW-1:0][DATA_W-1:0] rwFlat;
  logic [DATA_W-1:0]             auxNow;
  logic [FIELD_W-1:0]            typeField;
  logic [DATA_W-1:0]             typeWord;

  generate
    for (genvar g = 0; g < NUM_RW; g++) begin : g_reg
      logic [DATA_W-1:0] regQ;
      always_ff @(posedge clk) begin
        if (rst) begin
          regQ <= rwResetVal(g);
        end else if (strobe.wrEn[g]) begin
          regQ <= wdata & rwWriteMask(g);
        end
      end
      assign rwFlat[g] = regQ;
    end
  endgenerate

  // Type word is rebuilt from the live auxiliary value on every read.
  assign auxNow    = rwFlat[IDX_AUX];
  assign typeField = {auxNow[WAYSZ_LSB+2:WAYSZ_LSB], 1'b0, auxNow[ASSOC_BIT]};
  assign typeWord  = BASE_TYPE
                   | (DATA_W'(typeField) << TYPE_POS_D)
                   | (DATA_W'(typeField) << TYPE_POS_I);

  always_comb begin
    rdata = '0;
    case (strobe.rdSrc)
      RD_ID:   rdata = CACHE_ID;
      RD_TYPE: rdata = typeWord;
      RD_REG: begin
        if (strobe.rdIdx < IDX_W'(NUM_RW)) rdata = rwFlat[strobe.rdIdx];
      end
      default: rdata = '0;
    endcase
  end

  AST_CTRL_ONE_BIT: assert property (@(posedge clk) disable iff (rst) rwFlat[IDX_CTRL][DATA_W-1:1] == '0); // R4
  AST_AUX_AFTER_RESET: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (rwFlat[IDX_AUX] == AUX_RESET)); // R5
  AST_BAD_NO_WRITE: assert property (@(posedge clk) disable iff (rst) strobe.badAccess |-> (strobe.wrEn == '0)); // R10
  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst) (strobe.wrEn == '0) |=> $stable(rwFlat)); // R3
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst) $onehot0(strobe.wrEn)); // R6

endmodule

// File: rtl/cache_ctl_shim.sv
`timescale 1ns/1ps
module cache_ctl_shim
  import cache_shim_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [DATA_W-1:0] BASE_TYPE = 32'h1C10_0100,
  parameter logic [DATA_W-1:0] CACHE_ID  = 32'h4100_00C8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busReady,
  output logic              busErr
);

  shimStrobe_t       strobe;
  logic [OFS_W-1:0]  ofsView;

  assign ofsView  = busAddr[OFS_W-1:0];
  assign busReady = 1'b1;
  assign busErr   = strobe.badAccess;

  cache_shim_ctrl #(
    .ADDR_W   (ADDR_W),
    .MAINT_LO (13'h730),
    .MAINT_HI (13'h800)
  ) u_ctrl (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strobe   (strobe)
  );

  cache_shim_datapath #(
    .BASE_TYPE (BASE_TYPE),
    .CACHE_ID  (CACHE_ID)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .wdata  (busWdata),
    .rdata  (busRdata)
  );

  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst) busErr |-> (busRdata == '0)); // R10
  AST_MAINT_QUIET: assert property (@(posedge clk) disable iff (rst) (busSel && ofsView >= 12'h730 && ofsView < 12'h800) |-> (busRdata == '0 && !busErr)); // R3
  AST_ID_READ: assert property (@(posedge clk) disable iff (rst) (busSel && !busWrite && ofsView == 12'h000) |-> (busRdata == CACHE_ID)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !busSel |-> (busRdata == '0 && !busErr)); // R12
  AST_RO_WRITE_ERR: assert property (@(posedge clk) disable iff (rst) (busSel && busWrite && (ofsView == 12'h000 || ofsView == 12'h004)) |-> busErr); // R11

endmodule

// File: tb/cache_ctl_shim_tb.sv
`timescale 1ns/1ps
module cache_ctl_shim_tb;

  localparam int          ADDR_W    = 32;
  localparam logic [31:0] BASE_TYPE = 32'h1C10_0100;
  localparam logic [31:0] ID_WORD   = 32'h4100_00C8;
  localparam int          RAND_OPS  = 4000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [31:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busReady;
  logic        busErr;

  int vectors = 0;
  int miscompares = 0;
  logic done = 1'b0;

  // model: 0 ctrl, 1 aux, 2 tag, 3 data, 4 filter start, 5 filter end
  logic [31:0] mReg [6];

  always #10 clk = ~clk;

  cache_ctl_shim #(.ADDR_W(ADDR_W), .BASE_TYPE(BASE_TYPE)) u_dut (
    .clk(clk), .rst(rst), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busReady(busReady), .busErr(busErr)
  );

  function automatic bit inMaintWin(logic [11:0] o);
    return (o >= 12'h730) && (o < 12'h800);
  endfunction

  function automatic int regIndex(logic [11:0] o);
    case (o)
      12'h100: return 0;
      12'h104: return 1;
      12'h108: return 2;
      12'h10C: return 3;
      12'hC00: return 4;
      12'hC04: return 5;
      default: return -1;
    endcase
  endfunction

  function automatic bit isNullOfs(logic [11:0] o);
    return (o == 12'hF40) || (o == 12'hF60) || (o == 12'hF80);
  endfunction

  function automatic logic [31:0] expType();
    logic [31:0] f;
    f = {27'b0, mReg[1][19:17], 1'b0, mReg[1][16]};
    return BASE_TYPE | (f << 18) | (f << 6);
  endfunction

  function automatic logic [31:0] expRead(logic [11:0] o);
    if (inMaintWin(o) || isNullOfs(o)) return 32'h0;
    if (o == 12'h000) return ID_WORD;
    if (o == 12'h004) return expType();
    if (regIndex(o) >= 0) return mReg[regIndex(o)];
    return 32'h0;
  endfunction

  function automatic logic expErr(logic wr, logic [11:0] o);
    if (inMaintWin(o) || isNullOfs(o) || regIndex(o) >= 0) return 1'b0;
    if (o == 12'h000 || o == 12'h004) return wr;
    return 1'b1;
  endfunction

  function automatic string tagFor(logic wr, logic [11:0] o);
    if (inMaintWin(o)) return "R3";
    if (o == 12'h000) return wr ? "R11" : "R2";
    if (o == 12'h004) return wr ? "R11" : "R8";
    if (o == 12'h100) return "R4";
    if (o == 12'h104) return "R7";
    if (regIndex(o) >= 0) return "R6";
    if (isNullOfs(o)) return "R9";
    return "R10";
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 6; i++) mReg[i] = 32'h0;
    mReg[1] = 32'h0202_0000;
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] exp,
                       input string tag, input string what);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [31:0] addr,
                        input logic [31:0] data, input string tag);
    int idx;
    @(negedge clk);
    busSel = 1'b1; busWrite = wr; busAddr = addr; busWdata = data;
    #8;
    check(busRdata, wr ? 32'h0 : expRead(addr[11:0]), tag, "rdata");
    check({31'b0, busErr}, {31'b0, expErr(wr, addr[11:0])}, tag, "err");
    check({31'b0, busReady}, 32'h1, "R12", "ready");
    @(posedge clk);
    idx = regIndex(addr[11:0]);
    if (wr && idx >= 0) mReg[idx] = (idx == 0) ? {31'b0, data[0]} : data;
  endtask

  task automatic idle();
    @(negedge clk);
    busSel = 1'b0; busWrite = $urandom_range(1, 0) == 1; busAddr = $urandom;
    #8;
    check(busRdata, 32'h0, "R12", "idle rdata");
    check({31'b0, busErr}, 32'h0, "R12", "idle err");
    check({31'b0, busReady}, 32'h1, "R12", "idle ready");
    @(posedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    busSel = 1'b1; busWrite = 1'b1; busAddr = 32'h104; busWdata = 32'hFFFF_FFFF;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0; busSel = 1'b0;
    modelReset();
  endtask

  task automatic readAllReset(input string tag);
    access(1'b0, 32'h100, 32'h0, tag);
    access(1'b0, 32'h104, 32'h0, tag);
    access(1'b0, 32'h108, 32'h0, tag);
    access(1'b0, 32'h10C, 32'h0, tag);
    access(1'b0, 32'hC00, 32'h0, tag);
    access(1'b0, 32'hC04, 32'h0, tag);
  endtask

  localparam int NPICK = 18;
  function automatic logic [11:0] pickOfs(int k);
    case (k)
      0: return 12'h000;  1: return 12'h004;  2: return 12'h100;
      3: return 12'h104;  4: return 12'h108;  5: return 12'h10C;
      6: return 12'hC00;  7: return 12'hC04;  8: return 12'hF40;
      9: return 12'hF60; 10: return 12'hF80; 11: return 12'h730;
     12: return 12'h7FF; 13: return 12'h72F; 14: return 12'h800;
     15: return 12'h101; 16: return 12'h104; 17: return 12'h004;
      default: return 12'h000;
    endcase
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL R12 watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd13579));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R5 reset state
    readAllReset("R5");
    access(1'b0, 32'h000, 32'h0, "R2");
    access(1'b0, 32'h004, 32'h0, "R8");
    idle();

    // R4 control masking
    access(1'b1, 32'h100, 32'hFFFF_FFFF, "R4");
    access(1'b0, 32'h100, 32'h0, "R4");
    access(1'b1, 32'h100, 32'hFFFF_FFFE, "R4");
    access(1'b0, 32'h100, 32'h0, "R4");

    // R7 / R8 auxiliary and derived type, then clearing
    access(1'b1, 32'h104, 32'h000F_0000, "R7");
    access(1'b0, 32'h104, 32'h0, "R7");
    access(1'b0, 32'h004, 32'h0, "R8");
    check(expType(), 32'h1C74_0740, "R8", "bench type formula");
    access(1'b1, 32'h104, 32'h0000_0000, "R7");
    access(1'b0, 32'h004, 32'h0, "R8");
    access(1'b1, 32'h104, 32'hA5A5_5A5A, "R7");
    access(1'b0, 32'h004, 32'h0, "R8");

    // R6 full-width registers
    access(1'b1, 32'h108, 32'hDEAD_BEEF, "R6");
    access(1'b1, 32'h10C, 32'h1234_5678, "R6");
    access(1'b1, 32'hC00, 32'hFFFF_FFFF, "R6");
    access(1'b1, 32'hC04, 32'h8000_0001, "R6");
    access(1'b0, 32'h108, 32'h0, "R6");
    access(1'b0, 32'h10C, 32'h0, "R6");
    access(1'b0, 32'hC00, 32'h0, "R6");
    access(1'b0, 32'hC04, 32'h0, "R6");

    // R1 upper address bits ignored
    access(1'b0, 32'hABCD_E000, 32'h0, "R1");
    access(1'b1, 32'hFFFF_F108, 32'h0BAD_F00D, "R1");
    access(1'b0, 32'h0000_1108, 32'h0, "R1");
    access(1'b0, 32'h5555_5F40, 32'h0, "R1");

    // R3 maintenance window edges
    access(1'b1, 32'h730, 32'hFFFF_FFFF, "R3");
    access(1'b0, 32'h7FC, 32'h0, "R3");
    access(1'b0, 32'h7FF, 32'h0, "R3");
    access(1'b0, 32'h72C, 32'h0, "R10");
    access(1'b0, 32'h800, 32'h0, "R10");
    readAllReset("R3");

    // R9 null offsets
    access(1'b1, 32'hF40, 32'hFFFF_FFFF, "R9");
    access(1'b1, 32'hF60, 32'hFFFF_FFFF, "R9");
    access(1'b1, 32'hF80, 32'hFFFF_FFFF, "R9");
    access(1'b0, 32'hF60, 32'h0, "R9");

    // R11 read-only identity and type
    access(1'b1, 32'h000, 32'hFFFF_FFFF, "R11");
    access(1'b1, 32'h004, 32'hFFFF_FFFF, "R11");
    access(1'b0, 32'h000, 32'h0, "R11");
    access(1'b0, 32'h004, 32'h0, "R11");

    // R10 misaligned and unknown, error for one cycle only
    access(1'b1, 32'h101, 32'hFFFF_FFFF, "R10");
    idle();
    access(1'b0, 32'h101, 32'h0, "R10");
    access(1'b1, 32'hFFC, 32'h1, "R10");
    readAllReset("R10");

    // R5 mid-run reset beats a simultaneous write
    access(1'b1, 32'h100, 32'h1, "R4");
    access(1'b1, 32'h108, 32'h7777_7777, "R6");
    doReset();
    readAllReset("R5");

    // random mix
    for (int n = 0; n < RAND_OPS; n++) begin
      logic [11:0] o;
      logic [31:0] a;
      logic        wr;
      if ($urandom_range(7, 0) == 0) begin
        idle();
      end else begin
        if ($urandom_range(1, 0) == 0) o = pickOfs(int'($urandom_range(NPICK - 1, 0)));
        else o = 12'($urandom);
        a  = {20'($urandom), o};
        wr = $urandom_range(1, 0) == 1;
        access(wr, a, $urandom, tagFor(wr, o));
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule